// File: doc/BRIEF.md
# Serial TDM Time-Slot Interchange Switch

This block moves bytes between time slots of a few bit-serial time-division streams. A free-running position counter is forced back to the start of a frame by an active-low frame pulse. Every input stream is shifted into a byte once per channel, and each byte is written into a two-bank data memory. There is one bank per frame parity. A connection memory holds one 16-bit word for each output stream and channel.

During the last bit of each channel slot the block reads the word for the next output channel. It then loads that channel's parallel-to-serial shifter with one of two bytes. In connection mode this is the byte from the named source stream and channel. In message mode it is the literal byte stored in the word. Each output channel can also be left undriven. A drive-enable pin together with a control bit can turn off every output at once.

A small register port reads and writes both memories. It can also fill the whole connection memory with a 3-bit control pattern. The fill clears its own start bit when it ends.

Top module: `tdm_slot_switch`

## Requirements
- R1: Frame timing. The input bit sampled on the clock edge at which `frame_n` is low is bit 7 of channel 0 of a new frame. Each channel is 8 bits, MSB first. A frame is 32 channels (256 clocks) and restarts at any frame pulse, even an early one.
- R2: Output timing and connection mode. Output bits are aligned bit for bit with input positions: during the clock period that ends at the edge sampling input position q, `tx` carries output position q, MSB first. In connection mode, output channel k carries the data memory byte named by word bits [6:5] (source stream) and [4:0] (source channel).
- R3: Broadcast. Any number of output channels may name the same source channel, and each of them receives that source byte.
- R4: Variable delay (word bit 14 = 0). Output channel k of frame F carries source channel c from frame F when c < k. Otherwise it carries source channel c from frame F-1.
- R5: Constant delay (word bit 14 = 1). Every output channel of frame F carries source data from frame F-1, so a frame's bytes stay together.
- R6: Message mode (word bit 13 = 1). The output channel carries word bits [7:0] in every frame until the word is rewritten.
- R7: Per-channel enable. Word bit 15 = 0 holds `tx_en` low for that output channel's whole slot. Bit 15 = 1 lets `tx_en` go high.
- R8: Global standby. The control register is at address bit 7 = 1. When `drive_en` is low and control bit 0 is low, every `tx_en` is low whatever the per-channel bits say. If either of them is high, the per-channel bits apply.
- R9: Bulk fill. Control bit 1 is fill mode and bit 2 is fill start. When both are 1, every connection word becomes {control[15:13], 13'b0} within two frames. Bit 2 then clears itself.
- R10: While a fill runs, port writes are ignored. A start bit set without fill mode changes no connection word.
- R11: Reset. After reset, every `tx_en` is low and the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame pulse, one clock wide |
| rx | input | NS | Serial input streams |
| drive_en | input | 1 | Output drive enable; low together with control bit 0 low blanks all outputs |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | CMW+1 | Bit CMW selects the control register; otherwise {stream, channel} of a connection word |
| reg_wdata | input | 16 | Write data |
| tx | output | NS | Serial output streams |
| tx_en | output | NS | Output drive enables for the tri-state pads |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |

## Verification
The bench sweeps every stream and channel with frame-numbered data. The sources are chosen so that some lie before and some after the output channel, and one source feeds a whole stream. A design that read the wrong bank would be off by one frame on exactly one side of the c < k boundary. A design that did not bypass a byte written on the same edge would get the c = k-1 and channel-0 wrap cases wrong in both delay modes.

The bench also checks three other things. It sends an early frame pulse, which a counter that ignored the pulse would leave misaligned. It sweeps the four combinations of pin and control bit for standby. It writes during a fill, and a design that accepted that write would leave one word different from the fill pattern.

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch #(
  parameter int NS = 4,
  parameter int NC = 32,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(NC),
  localparam int CMW = SW + CW,
  localparam int AW = CMW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic [NS-1:0] rx,
  input  logic          drive_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [NS-1:0] tx,
  output logic [NS-1:0] tx_en,
  output logic [15:0]   reg_rdata
);
  localparam int PW  = CW + 3;
  localparam int NCM = NS * NC;

  logic [PW-1:0]  cnt, cur;
  logic [CW-1:0]  ch, ch_nx;
  logic           last_bit, wb, busy;
  logic [15:0]    ctl;
  logic [CMW-1:0] fill_idx;
  logic [15:0]    cm [NCM];
  logic [7:0]     dm [2*NCM];
  logic [7:0]     rx_sr [NS];
  logic [7:0]     tx_sr [NS];
  logic [NS-1:0]  tx_on;
  logic [15:0]    cw [NS];
  logic [7:0]     nxt [NS];
  logic [7:0]     rx_byte [NS];

  assign cur       = frame_n ? cnt : '0;
  assign ch        = cur[PW-1:3];
  assign ch_nx     = ch + 1'b1;
  assign last_bit  = &cur[2:0];
  assign busy      = ctl[1] & ctl[2];
  assign reg_rdata = reg_addr[CMW] ? ctl : cm[reg_addr[CMW-1:0]];

  for (genvar g = 0; g < NS; g++) begin : g_lane
    logic [SW-1:0] src_s;
    logic [CW-1:0] src_c;
    logic          bank;

    assign rx_byte[g] = {rx_sr[g][6:0], rx[g]};
    assign cw[g]      = cm[{SW'(g), ch_nx}];
    assign src_s      = cw[g][CMW-1:CW];
    assign src_c      = cw[g][CW-1:0];
    assign bank       = cw[g][14] ? ((&ch) ? wb : ~wb)
                                  : ((src_c <= ch) ? wb : ~wb);
    assign nxt[g]     = cw[g][13] ? cw[g][7:0]
                      : ((bank == wb) && (src_c == ch)) ? rx_byte[src_s]
                      : dm[{bank, src_s, src_c}];
    assign tx[g]      = tx_sr[g][7];
    assign tx_en[g]   = tx_on[g] & (drive_en | ctl[0]);

    assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && !cw[g][15]) |=> !tx_en[g]);
    assert_msg_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && cw[g][13]) |=> tx_sr[g] == $past(cw[g][7:0]));
    assert_serial_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !last_bit |=> tx[g] == $past(tx_sr[g][6]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      wb       <= 1'b0;
      ctl      <= '0;
      fill_idx <= '0;
      tx_on    <= '0;
      for (int s = 0; s < NS; s++) begin
        rx_sr[s] <= '0;
        tx_sr[s] <= '0;
      end
    end else begin
      cnt <= cur + 1'b1;
      if (!frame_n) wb <= ~wb;
      for (int s = 0; s < NS; s++) begin
        rx_sr[s] <= rx_byte[s];
        if (last_bit) begin
          tx_sr[s] <= nxt[s];
          tx_on[s] <= cw[s][15];
        end else begin
          tx_sr[s] <= {tx_sr[s][6:0], 1'b0};
        end
      end
      if (busy) begin
        fill_idx <= fill_idx + 1'b1;
        if (&fill_idx) ctl[2] <= 1'b0;
      end else if (reg_we && reg_addr[CMW]) begin
        ctl <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && last_bit)
      for (int s = 0; s < NS; s++)
        dm[{wb, SW'(s), ch}] <= rx_byte[s];
  end

  always_ff @(posedge clk) begin
    if (busy)
      cm[fill_idx] <= {ctl[15:13], 13'b0};
    else if (rst_n && reg_we && !reg_addr[CMW])
      cm[reg_addr[CMW-1:0]] <= reg_wdata;
  end

  assert_frame_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> cnt == PW'(1));
  assert_fill_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && &fill_idx) |=> (!ctl[2] && fill_idx == '0));
  assert_ctl_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (ctl[1] && ctl[15:13] == $past(ctl[15:13]) && ctl[0] == $past(ctl[0])));
endmodule

// File: tb/tdm_slot_switch_tb.sv
module tdm_slot_switch_tb_top;
  logic        clk = 0, rst_n = 0, frame_n = 1, drv = 1, reg_we = 0;
  logic [3:0]  rx = '0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [3:0]  tx, tx_en;
  logic [15:0] reg_rdata;
  int nchk = 0, nfail = 0, gcyc = 0, chk_from = 1 << 30;
  bit run = 0, jump = 0, ctl_drv = 0, done = 0;
  string ph = "";
  logic [15:0] cmm [128];
  logic [7:0]  acc [4];

  always #10 clk = ~clk;

  tdm_slot_switch dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .rx(rx), .drive_en(drv),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .tx(tx), .tx_en(tx_en), .reg_rdata(reg_rdata));

  function automatic logic [7:0] pat(int f, int s, int c);
    return 8'(f * 37 + s * 71 + c * 13 + 5);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", ph, tag, act, exp);
    end
  endtask

  always @(negedge clk) if (run) begin
    int q, pos, f;
    q = gcyc; pos = q % 256; f = q / 256;
    if (f >= chk_from) begin
      for (int s = 0; s < 4; s++) begin
        acc[s] = {acc[s][6:0], tx[s]};
        if (pos % 8 == 7) begin
          int k, c, fs;
          logic [15:0] w;
          logic [1:0] ss;
          logic en_e;
          logic [7:0] e;
          k = pos / 8;
          w = cmm[s * 32 + k];
          en_e = w[15] & (drv | ctl_drv);
          chk(tx_en[s] == en_e, w[15] ? "R8 enable" : "R7 enable", tx_en[s], en_e);
          if (en_e) begin
            if (w[13]) begin
              chk(acc[s] == w[7:0], "R6 message", acc[s], w[7:0]);
            end else begin
              ss = w[6:5]; c = w[4:0];
              fs = w[14] ? f - 1 : (c < k ? f : f - 1);
              e = pat(fs, ss, c);
              chk(acc[s] == e, w[14] ? "R5 const" : (ss == 0 && c == 5) ? "R3 bcast"
                  : (c < k ? "R4 var" : "R2 conn"), acc[s], e);
            end
          end
        end
      end
    end
    if (jump) begin gcyc = (gcyc / 256 + 1) * 256; jump = 0; end
    q = gcyc; pos = q % 256; f = q / 256;
    frame_n = (pos != 0);
    for (int s = 0; s < 4; s++) begin
      logic [7:0] b;
      b = pat(f, s, pos / 8);
      rx[s] = b[7 - pos % 8];
    end
    gcyc++;
  end

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic prog(int s, int k, logic [15:0] w);
    wr(8'(s * 32 + k), w);
    cmm[s * 32 + k] = w;
  endtask

  task automatic watch(int frames);
    chk_from = gcyc / 256 + 2;
    repeat ((frames + 2) * 256) @(negedge clk);
    chk_from = 1 << 30;
  endtask

  function automatic logic [15:0] src(int s, int k);
    if (s == 3) return 16'(5);
    return 16'((((s + 1) % 4) << 5) | ((k * 7 + 3) % 32));
  endfunction

  initial begin
    logic [15:0] d;
    repeat (4) @(posedge clk);
    #1 chk(tx_en == 4'b0, "R11 tx_en", tx_en, 0);
    reg_addr = 8'h80; #1 chk(reg_rdata == 16'h0, "R11 ctl", reg_rdata, 0);
    @(negedge clk) run = 1;
    @(negedge clk) rst_n = 1;

    for (int s = 0; s < 4; s++) for (int k = 0; k < 32; k++) prog(s, k, 16'h8000 | src(s, k));
    watch(2);

    ph = "R1 realign";
    repeat (100) @(negedge clk);
    jump = 1;
    watch(1);
    ph = "";

    for (int s = 0; s < 4; s++) for (int k = 0; k < 32; k++) prog(s, k, 16'hC000 | src(s, k));
    watch(2);

    for (int s = 0; s < 4; s++) for (int k = 0; k < 32; k++)
      if (k % 3 == 0) prog(s, k, 16'hA000 | 16'(8'(k * 9 + s)));
      else if (k % 3 == 1) prog(s, k, src(s, k));
      else prog(s, k, 16'hC000 | src(s, k));
    watch(2);

    drv = 0; ctl_drv = 0;
    watch(1);
    wr(8'h80, 16'h0001); ctl_drv = 1;
    watch(1);
    drv = 1; wr(8'h80, 16'h0000); ctl_drv = 0;

    wr(8'h80, 16'hA004);
    repeat (300) @(negedge clk);
    rd(8'd10, d); chk(d == cmm[10], "R10 no-mode", d, cmm[10]);
    rd(8'h80, d); chk(d == 16'hA004, "R10 go kept", d, 16'hA004);
    wr(8'h80, 16'hA006);
    wr(8'h00, 16'h1234);
    begin
      int n;
      n = 0;
      do begin rd(8'h80, d); n++; end while (d[2] && n < 1000);
      chk(n <= 512, "R9 duration", n, 512);
      chk(d == 16'hA002, "R9 self-clear", d, 16'hA002);
    end
    for (int i = 0; i < 128; i++) begin
      rd(8'(i), d);
      chk(d == 16'hA000, i == 0 ? "R10 write ignored" : "R9 fill", d, 16'hA000);
      cmm[i] = 16'hA000;
    end
    watch(1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule